// File: doc/BRIEF.md
# Opcode Pair Frequency Profiler

This block sits beside the fetch path of a small stack-machine core and builds a histogram of which instruction follows which. Every executed opcode byte arrives with a strobe. Opcodes that carry an encoded stack offset or immediate payload are first reduced to a single class code. Each class code is then joined with the class code that came before it to form a 16-bit pair key. An associative table of saturating counters keeps a count for each distinct key it has seen.

Software walks the table through a registered readout port. It supplies an entry index and, one cycle later, gets that entry's key, its count and an occupied flag. Keys that arrive when every entry is taken are not lost silently: they are tallied in one separate overflow counter. A synchronous clear input and the active-low reset both return the profiler to an empty table, so that a fresh measurement window can start at any time.

Top module: `oppair_profiler`

## Requirements
- R1: An opcode byte with bit 7 set (0x80 to 0xFF) is counted under class code 0x80.
- R2: An opcode byte in 0x60 to 0x7F is counted under class code 0x60.
- R3: An opcode byte in 0x40 to 0x5F is counted under class code 0x40.
- R4: An opcode byte in 0x00 to 0x3F, including 0x38 and 0x05, is counted unchanged as its own class code.
- R5: The pair key carries the class of the earlier opcode in bits 15:8 and the class of the later opcode in bits 7:0. Two successive immediate pushes form key 0x8080.
- R6: After reset or clear, the first strobed opcode forms no pair. Cycles with op_valid low are ignored and do not break the adjacency of the strobed opcodes around them.
- R7: A key not yet in the table takes the lowest-index free entry with count 1. A key already in the table increments the count of its entry, and a key is never held in two entries.
- R8: When every entry is occupied, a new key leaves the table unchanged and increments ovf_count. Keys already in the table still increment their own entries.
- R9: Entry counts and ovf_count saturate at all-ones and never wrap.
- R10: rd_idx is sampled at a clock edge, and rd_key, rd_count and rd_valid show that entry from the next cycle onwards. An unoccupied entry reads valid 0, key 0 and count 0. An opcode strobed at edge t is reflected in a read requested at edge t+2 or later.
- R11: Reset (rst_n low) or clr high at a clock edge empties every entry, zeroes ovf_count and the readout, and forgets the previous opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of all profiler state |
| op_valid | input | 1 | Strobe marking an executed opcode on op_byte |
| op_byte | input | 8 | Executed opcode byte |
| rd_idx | input | IDX_W | Table entry to read out |
| rd_key | output | 16 | Pair key of the selected entry |
| rd_count | output | CNT_W | Occurrence count of the selected entry |
| rd_valid | output | 1 | Selected entry is occupied |
| ovf_count | output | CNT_W | Number of keys dropped because the table was full |

## Verification
The embedded properties assume that clr is a clean synchronous level and that op_byte is driven to known values whenever op_valid is high. They also assume that rd_idx names an existing entry. Under those conditions they require unique keys, a table that fills from index 0 with no gaps, counts that never fall except through a clear, and overflow that grows only when the table is full. The stimulus changes every input just after a clock edge, and it only ever requests indices that exist. It keeps the full 32-bit instance in its non-saturating range and uses a second, narrow instance with two entries to reach the saturation and overflow limits within a few dozen opcodes.

// File: rtl/oppair_pkg.sv
// Package: shared constants and the opcode folding function.
// Assumes opcode bytes are 8 bits; class codes are also 8 bits.
package oppair_pkg;
    localparam int OP_W  = 8;
    localparam int KEY_W = 2 * OP_W;

    localparam logic [OP_W-1:0] CLS_PUSH  = 8'h80;
    localparam logic [OP_W-1:0] CLS_LOAD  = 8'h60;
    localparam logic [OP_W-1:0] CLS_STORE = 8'h40;

    // Reduce an opcode that carries payload bits to its class code.
    function automatic logic [OP_W-1:0] fold_opcode(input logic [OP_W-1:0] op);
        if (op[7])                 return CLS_PUSH;
        else if (op[7:5] == 3'b011) return CLS_LOAD;
        else if (op[7:5] == 3'b010) return CLS_STORE;
        else                        return op;
    endfunction
endpackage

// File: rtl/oppair_classifier.sv
// Module: oppair_classifier
// Combinational fold of a raw opcode byte into its class code.
// Assumes the caller qualifies the result with its own valid strobe.
module oppair_classifier
    import oppair_pkg::*;
(
    input  logic [OP_W-1:0] op_in,
    output logic [OP_W-1:0] cls_out
);
    // Class lookup through the shared folding function.
    always_comb begin
        cls_out = fold_opcode(op_in);
    end
endmodule

// File: rtl/oppair_former.sv
// Module: oppair_former
// Remembers the previous class code and emits a registered pair key
// for each strobed class once a previous class exists.
// Assumes clr and rst_n are synchronous; clr wins over a strobe.
module oppair_former
    import oppair_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  in_cls,
    output logic             pair_valid,
    output logic [KEY_W-1:0] pair_key
);
    logic [OP_W-1:0] prev_cls_q;
    logic            have_prev_q;

    // Track the previous class and whether one has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            prev_cls_q  <= '0;
            have_prev_q <= 1'b0;
        end else if (in_valid) begin
            prev_cls_q  <= in_cls;
            have_prev_q <= 1'b1;
        end
    end

    // Register the pair key when a strobe follows a known class.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pair_valid <= 1'b0;
            pair_key   <= '0;
        end else begin
            pair_valid <= in_valid && have_prev_q;
            if (in_valid && have_prev_q)
                pair_key <= {prev_cls_q, in_cls};
        end
    end

    // The first strobe after reset or clear forms no pair.
    assert_prime_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !have_prev_q && !clr) |=> !pair_valid);

    // The low half of a pair key is the class strobed one cycle earlier.
    assert_key_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && have_prev_q && !clr) |=> (pair_key[OP_W-1:0] == $past(in_cls)));
endmodule

// File: rtl/oppair_table.sv
// Module: oppair_table
// Associative table of pair keys with saturating counters, an overflow
// counter for keys that find no room, and a registered readout port.
// Assumes at most one update per cycle and rd_idx below ENTRIES.
module oppair_table
    import oppair_pkg::*;
#(
    parameter  int ENTRIES = 16,
    parameter  int CNT_W   = 32,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd_valid,
    input  logic [KEY_W-1:0] upd_key,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [KEY_W-1:0] rd_key,
    output logic [CNT_W-1:0] rd_count,
    output logic             rd_valid,
    output logic [CNT_W-1:0] ovf_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [KEY_W-1:0] key_q [ENTRIES];
    logic [CNT_W-1:0] cnt_q [ENTRIES];
    logic [ENTRIES-1:0] used_q;
    logic [ENTRIES-1:0] hit_vec;
    logic               any_hit;
    logic               free_ok;
    logic [IDX_W-1:0]   free_idx;

    // Pick the lowest unoccupied entry for a new key.
    always_comb begin
        free_ok  = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!used_q[i]) begin
                free_ok  = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign any_hit = |hit_vec;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
            // Match the incoming key against this entry.
            assign hit_vec[g] = used_q[g] && (key_q[g] == upd_key);

            // Update this entry on a hit or when it is chosen for a new key.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    used_q[g] <= 1'b0;
                    key_q[g]  <= '0;
                    cnt_q[g]  <= '0;
                end else if (upd_valid) begin
                    if (hit_vec[g]) begin
                        if (cnt_q[g] != CNT_MAX)
                            cnt_q[g] <= cnt_q[g] + CNT_ONE;
                    end else if (!any_hit && free_ok && (free_idx == IDX_W'(g))) begin
                        used_q[g] <= 1'b1;
                        key_q[g]  <= upd_key;
                        cnt_q[g]  <= CNT_ONE;
                    end
                end
            end

            // A count only falls through reset or clear.
            assert_count_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !clr |=> (cnt_q[g] >= $past(cnt_q[g])));
        end
    endgenerate

    // Count keys that arrive when no entry is left.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            ovf_count <= '0;
        else if (upd_valid && !any_hit && !free_ok && (ovf_count != CNT_MAX))
            ovf_count <= ovf_count + CNT_ONE;
    end

    // Registered readout of the selected entry.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_key   <= '0;
            rd_count <= '0;
            rd_valid <= 1'b0;
        end else if (32'(rd_idx) < ENTRIES) begin
            rd_key   <= key_q[rd_idx];
            rd_count <= cnt_q[rd_idx];
            rd_valid <= used_q[rd_idx];
        end else begin
            rd_key   <= '0;
            rd_count <= '0;
            rd_valid <= 1'b0;
        end
    end

    // A key is never held by two entries.
    assert_unique_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // Occupied entries form a gap-free run starting at index 0.
    assert_fill_prefix_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((used_q + 1'b1) & used_q) == '0);

    // Overflow only grows while every entry is occupied.
    assert_ovf_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((ovf_count == $past(ovf_count)) || (&$past(used_q))));
endmodule

// File: rtl/oppair_profiler.sv
// Module: oppair_profiler (top)
// Folds strobed opcodes into classes, forms adjacent pair keys and
// counts them in an associative table readable by index.
// Assumes synchronous active-low reset and a synchronous clear.
module oppair_profiler
    import oppair_pkg::*;
#(
    parameter  int ENTRIES = 16,
    parameter  int CNT_W   = 32,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             op_valid,
    input  logic [7:0]       op_byte,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [15:0]      rd_key,
    output logic [CNT_W-1:0] rd_count,
    output logic             rd_valid,
    output logic [CNT_W-1:0] ovf_count
);
    logic [OP_W-1:0]  cls;
    logic             pair_v;
    logic [KEY_W-1:0] pair_k;

    oppair_classifier u_cls (
        .op_in   (op_byte),
        .cls_out (cls)
    );

    oppair_former u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .in_valid   (op_valid),
        .in_cls     (cls),
        .pair_valid (pair_v),
        .pair_key   (pair_k)
    );

    oppair_table #(
        .ENTRIES (ENTRIES),
        .CNT_W   (CNT_W)
    ) u_tab (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .upd_valid (pair_v),
        .upd_key   (pair_k),
        .rd_idx    (rd_idx),
        .rd_key    (rd_key),
        .rd_count  (rd_count),
        .rd_valid  (rd_valid),
        .ovf_count (ovf_count)
    );

    // Pushes always land in the push class.
    assert_push_class_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_byte[7]) |-> (cls == 8'h80));

    // Every class code is one of the folded codes or below 0x40.
    assert_class_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> ((cls < 8'h40) || (cls == 8'h40) || (cls == 8'h60) || (cls == 8'h80)));
endmodule

// File: tb/oppair_profiler_tb.sv
module oppair_profiler_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;
    // Each vector: first opcode, second opcode, expected pair key.
    localparam logic [31:0] VEC [NVEC] = '{
        {8'h60, 8'h60, 16'h6060},  // R2
        {8'h4F, 8'h44, 16'h4040},  // R3
        {8'h85, 8'h38, 16'h8038},  // R1 R4
        {8'h41, 8'h7F, 16'h4060},  // R2 R3
        {8'h61, 8'hFF, 16'h6080},  // R1 R2
        {8'h38, 8'h6A, 16'h3860},  // R4
        {8'h80, 8'h80, 16'h8080},  // R5
        {8'hC3, 8'h05, 16'h8005},  // R1 R4
        {8'h05, 8'h5E, 16'h0540},  // R3 R5
        {8'h0D, 8'h3D, 16'h0D3D},  // R4
        {8'h3F, 8'h00, 16'h3F00}   // R4
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic op_valid = 1'b0;
    logic [7:0] op_byte = '0;
    logic [3:0] rd_idx = '0;
    logic [15:0] rd_key;
    logic [31:0] rd_count;
    logic rd_valid;
    logic [31:0] ovf_count;

    logic s_clr = 1'b0;
    logic s_valid = 1'b0;
    logic [7:0] s_op = '0;
    logic [0:0] s_idx = '0;
    logic [15:0] s_key;
    logic [3:0] s_count;
    logic s_rvalid;
    logic [3:0] s_ovf;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oppair_profiler dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .op_valid(op_valid), .op_byte(op_byte),
        .rd_idx(rd_idx), .rd_key(rd_key), .rd_count(rd_count), .rd_valid(rd_valid),
        .ovf_count(ovf_count)
    );

    oppair_profiler #(.ENTRIES(2), .CNT_W(4)) sat_i (
        .clk(clk), .rst_n(rst_n), .clr(s_clr), .op_valid(s_valid), .op_byte(s_op),
        .rd_idx(s_idx), .rd_key(s_key), .rd_count(s_count), .rd_valid(s_rvalid),
        .ovf_count(s_ovf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_op(input logic [7:0] b);
        op_valid = 1'b1; op_byte = b;
        @(posedge clk); #1;
        op_valid = 1'b0;
    endtask

    task automatic s_put(input logic [7:0] b);
        s_valid = 1'b1; s_op = b;
        @(posedge clk); #1;
        s_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic do_clear();
        clr = 1'b1; @(posedge clk); #1; clr = 1'b0;
    endtask

    task automatic rd(input int idx);
        rd_idx = 4'(idx); @(posedge clk); #1;
    endtask

    task automatic s_rd(input int idx);
        s_idx = 1'(idx); @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        // R11: reset state
        rd(0);
        chk("R11 reset valid", 32'(rd_valid), 0);
        chk("R11 reset count", rd_count, 0);
        chk("R11 reset ovf", ovf_count, 0);

        // Vector walk: class folding and key layout (R1 R2 R3 R4 R5)
        for (int v = 0; v < NVEC; v++) begin
            do_clear();
            put_op(VEC[v][31:24]);
            put_op(VEC[v][23:16]);
            settle();
            rd(0);
            chk("R5 vector key", 32'(rd_key), 32'(VEC[v][15:0]));
            chk("R7 vector count", rd_count, 1);
        end

        // R6: a single opcode only primes
        do_clear();
        put_op(8'h60);
        settle(); rd(0);
        chk("R6 prime no pair", 32'(rd_valid), 0);
        // R6: idle gaps do not break adjacency
        repeat (3) @(posedge clk); #1;
        put_op(8'h61);
        settle(); rd(0);
        chk("R6 gap key", 32'(rd_key), 32'h6060);
        chk("R6 gap count", rd_count, 1);

        // R7: repeated keys reuse entries, new keys fill lowest free
        do_clear();
        put_op(8'h10); put_op(8'h20); put_op(8'h10); put_op(8'h20); put_op(8'h10);
        settle();
        rd(0);
        chk("R7 idx0 key", 32'(rd_key), 32'h1020);
        chk("R7 idx0 count", rd_count, 2);
        // R10: output still shows previous entry before the next edge
        rd_idx = 4'd1; #2;
        chk("R10 latency hold", 32'(rd_key), 32'h1020);
        @(posedge clk); #1;
        chk("R7 idx1 key", 32'(rd_key), 32'h2010);
        chk("R7 idx1 count", rd_count, 2);
        rd(2);
        chk("R10 unused valid", 32'(rd_valid), 0);
        chk("R10 unused key", 32'(rd_key), 0);

        // R8: fill all 16 entries, then overflow
        do_clear();
        for (int k = 0; k < 18; k++) put_op(8'(k));
        settle();
        rd(15);
        chk("R8 last entry key", 32'(rd_key), 32'h0F10);
        chk("R8 ovf one", ovf_count, 1);
        put_op(8'h00);
        put_op(8'h01);
        settle();
        chk("R8 ovf two", ovf_count, 2);
        rd(0);
        chk("R8 hit when full", rd_count, 2);

        // R11: clear empties table and overflow
        do_clear();
        rd(0);
        chk("R11 clear valid", 32'(rd_valid), 0);
        chk("R11 clear ovf", ovf_count, 0);
        put_op(8'h05);
        settle(); rd(0);
        chk("R11 clear forgets prev", 32'(rd_valid), 0);

        // R9: saturation on the narrow instance
        for (int k = 0; k < 20; k++) s_put(8'h80);
        settle(); s_rd(0);
        chk("R9 count saturates", 32'(s_count), 15);
        chk("R5 push pair key", 32'(s_key), 32'h8080);
        s_clr = 1'b1; @(posedge clk); #1; s_clr = 1'b0;
        for (int k = 1; k < 25; k++) s_put(8'(k));
        settle(); s_rd(1);
        chk("R8 small table idx1", 32'(s_key), 32'h0203);
        chk("R9 ovf saturates", 32'(s_ovf), 15);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule